// File: doc/BRIEF.md
# Modulo Wrap Timer Counter

This block is a 16-bit up-counter that advances once per system-clock cycle in which a prescaled timer-clock enable is high. When the count equals a programmable wrap value and a timer-clock enable arrives, the counter returns to zero and a sticky wrap flag is raised. The flag can drive an interrupt request through an enable bit. All flops run on the system clock. Reset is synchronous and active-high.

Software loads the wrap value over an 8-bit register port as two bytes. Writing the upper byte opens a hold window, and writing the lower byte closes it. While the window is open, wraps still happen but never raise the flag, and the interrupt request is gated off. A half-loaded value therefore cannot produce a spurious event. A counter-reset command returns the count to zero and leaves the wrap value as it is. Software is expected to issue that command before loading a new wrap value.

Top module: `modtmr_top`

## Requirements
- R1: After reset the count is 0x0000, the flag is 0, the interrupt enable is 0, `irq` is 0, the hold window is closed, and both wrap-value bytes read 0xFF (wrap value 0xFFFF).
- R2: In a cycle with `tick` high, no counter-reset command, and a count different from the wrap value, the count increases by one. In a cycle with `tick` low and no counter-reset command, the count keeps its value.
- R3: In a cycle with `tick` high, no counter-reset command, and a count equal to the wrap value, the count becomes 0x0000 and the flag (read at address 0, bit 7) becomes 1 on the same edge, unless the hold window is open. A wrap value of 0 gives a wrap on every tick.
- R4: A write to address 2 (upper byte) opens the hold window, and a write to address 3 (lower byte) closes it. A wrap while the window is open leaves the flag unchanged.
- R5: `irq` is 1 exactly when the flag is 1, the interrupt enable (address 0, bit 6) is 1, and the hold window is closed.
- R6: The flag is cleared by a read of address 0 while the flag is 1, followed by a write to address 0 with bit 7 = 0. Any write to address 0 consumes the armed state. A write with bit 7 = 0 that was not preceded by such a read, or a write with bit 7 = 1, leaves the flag unchanged.
- R7: If a wrap that would set the flag happens on the same edge as a clearing write, the flag ends up 1.
- R8: A write to address 0 with bit 5 = 1 loads the count with 0x0000 on that edge, ignores a `tick` in the same cycle, and leaves the wrap value unchanged.
- R9: Register map: address 0 reads {flag, enable, 6'b0}, with bit 5 always reading 0. Address 1 reads 0x00. Addresses 2 and 3 read the upper and lower wrap bytes. `rdata` is combinational from `addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled timer-clock enable |
| sel_wr | input | 1 | Register write strobe |
| sel_rd | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| count | output | 16 | Current count |
| irq | output | 1 | Wrap interrupt request |

## Verification
A counter that skips or repeats a value shows at `count` on the very next tick. A wrong compare shifts the zero return, and the flag arrives early, late, or not at all, which `rdata` reveals one cycle after the offending tick. A stuck hold window or a wrong clear-arming state shows through `irq` and the flag bit within one register access. The set-versus-clear race is exercised on a single shared edge.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_RSV  = 2'd1,
        ADDR_MODH = 2'd2,
        ADDR_MODL = 2'd3
    } reg_addr_e;

    localparam int BIT_FLAG = 7;
    localparam int BIT_IE   = 6;
    localparam int BIT_CRST = 5;

    typedef struct packed {
        logic             wr;
        logic             rd;
        reg_addr_e        addr;
        logic [BYTE_W-1:0] data;
    } reg_req_t;

    function automatic logic hits(input reg_req_t r, input reg_addr_e a);
        return r.wr && (r.addr == a);
    endfunction
endpackage

// File: rtl/modtmr_counter.sv
module modtmr_counter
    import modtmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         crst,
    input  logic [W-1:0] wrap_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic at_top;
    assign at_top = (cnt == wrap_val);
    assign wrap   = tick && !crst && at_top;

    always_ff @(posedge clk) begin
        if (rst || crst)
            cnt <= '0;
        else if (tick)
            cnt <= at_top ? '0 : cnt + W'(1);
    end
endmodule

// File: rtl/modtmr_modreg.sv
module modtmr_modreg
    import modtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  wrap_val,
    output logic              hold
);
    logic [BYTE_W-1:0] hi_q, lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '1;
            lo_q <= '1;
            hold <= 1'b0;
        end else begin
            if (wr_hi) begin
                hi_q <= wdata;
                hold <= 1'b1;
            end
            if (wr_lo) begin
                lo_q <= wdata;
                hold <= 1'b0;
            end
        end
    end

    assign wrap_val = {hi_q, lo_q};
endmodule

// File: rtl/modtmr_flag.sv
module modtmr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic rd_ctrl,
    input  logic wr_ctrl,
    input  logic wbit,
    output logic flag
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (wr_ctrl)
            armed <= 1'b0;
        else if (rd_ctrl && flag)
            armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set_req)
            flag <= 1'b1;
        else if (wr_ctrl && armed && !wbit)
            flag <= 1'b0;
    end
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
    import modtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              sel_wr,
    input  logic              sel_rd,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              irq
);
    reg_req_t         req;
    logic             wr_ctrl, rd_ctrl, crst, wrap, hold, flag, ie;
    logic [CNT_W-1:0] wrap_val;

    assign req     = '{wr: sel_wr, rd: sel_rd, addr: reg_addr_e'(addr), data: wdata};
    assign wr_ctrl = hits(req, ADDR_CTRL);
    assign rd_ctrl = req.rd && (req.addr == ADDR_CTRL);
    assign crst    = wr_ctrl && req.data[BIT_CRST];

    modtmr_counter #(.W(CNT_W)) i_cnt (
        .clk(clk), .rst(rst), .tick(tick), .crst(crst),
        .wrap_val(wrap_val), .cnt(count), .wrap(wrap)
    );

    modtmr_modreg i_mod (
        .clk(clk), .rst(rst),
        .wr_hi(hits(req, ADDR_MODH)), .wr_lo(hits(req, ADDR_MODL)),
        .wdata(req.data), .wrap_val(wrap_val), .hold(hold)
    );

    modtmr_flag i_flag (
        .clk(clk), .rst(rst), .set_req(wrap && !hold),
        .rd_ctrl(rd_ctrl), .wr_ctrl(wr_ctrl),
        .wbit(req.data[BIT_FLAG]), .flag(flag)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ie <= 1'b0;
        else if (wr_ctrl)
            ie <= req.data[BIT_IE];
    end

    assign irq = flag && ie && !hold;

    always_comb begin
        unique case (req.addr)
            ADDR_CTRL: rdata = {flag, ie, 6'b0};
            ADDR_MODH: rdata = wrap_val[CNT_W-1:BYTE_W];
            ADDR_MODL: rdata = wrap_val[BYTE_W-1:0];
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/modtmr_chk.sv
module modtmr_chk
    import modtmr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             crst,
    input logic             hold,
    input logic             flag,
    input logic             ie,
    input logic             irq,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] wrap_val
);
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !crst && count != wrap_val) |=> count == $past(count) + CNT_W'(1));

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !crst) |=> $stable(count));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !crst && count == wrap_val && !hold) |=> (count == '0) && flag);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> !$past(hold));

    assert_irq_R5: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag && ie && !hold));

    assert_crst_R8: assert property (@(posedge clk) disable iff (rst)
        crst |=> (count == '0) && $stable(wrap_val));
endmodule

bind modtmr_top modtmr_chk i_chk (
    .clk(clk), .rst(rst), .tick(tick), .crst(crst), .hold(hold),
    .flag(flag), .ie(ie), .irq(irq), .count(count), .wrap_val(wrap_val)
);

// File: tb/test_modtmr_top.sv
module test_modtmr_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        sel_wr = 1'b0;
    logic        sel_rd = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic [15:0] count;
    logic        irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    modtmr_top i_modtmr_top (
        .clk(clk), .rst(rst), .tick(tick), .sel_wr(sel_wr), .sel_rd(sel_rd),
        .addr(addr), .wdata(wdata), .rdata(rdata), .count(count), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel_wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        sel_rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    // bit7=1 leaves the flag alone, bit5 resets the count, bit6 is enable
    task automatic restart(input logic en);
        wr(2'd0, {1'b1, en, 1'b1, 5'd0});
    endtask

    task automatic load_mod(input logic [15:0] m);
        wr(2'd2, m[15:8]);
        wr(2'd3, m[7:0]);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 count", count, 16'h0);
        chk("R1 irq", irq, 1'b0);
        rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
        rd(2'd2, d); chk("R1 modh", d, 8'hFF);
        rd(2'd3, d); chk("R1 modl", d, 8'hFF);
        rd(2'd1, d); chk("R9 rsv", d, 8'h00);
    endtask

    task automatic t_count();
        logic [7:0] d;
        load_mod(16'd5);
        restart(1'b0);
        chk("R8 count zero", count, 16'h0);
        ticks(3); chk("R2 count3", count, 16'd3);
        repeat (4) @(negedge clk);
        chk("R2 idle hold", count, 16'd3);
        ticks(2); chk("R2 count5", count, 16'd5);
        rd(2'd0, d); chk("R3 no flag yet", d[7], 1'b0);
        ticks(1); chk("R3 wrapped", count, 16'd0);
        rd(2'd0, d); chk("R3 flag set", d[7], 1'b1);
        chk("R9 crst reads 0", d[5], 1'b0);
    endtask

    task automatic t_irq_clear();
        logic [7:0] d;
        wr(2'd0, 8'hC0);
        chk("R5 irq on", irq, 1'b1);
        wr(2'd0, 8'h40);
        chk("R6 unarmed write keeps flag", irq, 1'b1);
        rd(2'd0, d); chk("R6 flag still", d, 8'hC0);
        wr(2'd0, 8'h40);
        rd(2'd0, d); chk("R6 flag cleared", d, 8'h40);
        chk("R5 irq off", irq, 1'b0);
    endtask

    task automatic t_hold();
        logic [7:0] d;
        restart(1'b1);
        wr(2'd2, 8'h00);
        ticks(6);
        chk("R4 wrapped", count, 16'd0);
        rd(2'd0, d); chk("R4 no flag in hold", d[7], 1'b0);
        wr(2'd3, 8'h05);
        ticks(6);
        rd(2'd0, d); chk("R4 flag after close", d[7], 1'b1);
        chk("R5 irq", irq, 1'b1);
        wr(2'd2, 8'h00);
        chk("R5 irq gated", irq, 1'b0);
        wr(2'd3, 8'h05);
        chk("R5 irq back", irq, 1'b1);
    endtask

    task automatic t_race();
        logic [7:0] d;
        rd(2'd0, d);
        wr(2'd0, 8'h40);
        restart(1'b1);
        ticks(6);
        rd(2'd0, d); chk("R7 pre flag", d[7], 1'b1);
        ticks(5);
        chk("R7 at top", count, 16'd5);
        @(negedge clk);
        tick = 1'b1; sel_wr = 1'b1; addr = 2'd0; wdata = 8'h40;
        @(negedge clk);
        tick = 1'b0; sel_wr = 1'b0;
        chk("R7 wrap", count, 16'd0);
        rd(2'd0, d); chk("R7 set wins", d[7], 1'b1);
    endtask

    task automatic t_crst();
        logic [7:0] d;
        ticks(3);
        @(negedge clk);
        tick = 1'b1; sel_wr = 1'b1; addr = 2'd0; wdata = 8'hA0;
        @(negedge clk);
        tick = 1'b0; sel_wr = 1'b0;
        chk("R8 reset beats tick", count, 16'd0);
        rd(2'd3, d); chk("R8 mod kept", d, 8'h05);
    endtask

    task automatic t_zero();
        logic [7:0] d;
        rd(2'd0, d);
        wr(2'd0, 8'h00);
        load_mod(16'd0);
        restart(1'b0);
        rd(2'd0, d); chk("R3 zero no flag", d[7], 1'b0);
        ticks(1);
        chk("R3 zero stays", count, 16'd0);
        rd(2'd0, d); chk("R3 zero flag", d[7], 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_count();
        t_irq_clear();
        t_hold();
        t_race();
        t_crst();
        t_zero();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule